// File: doc/BRIEF.md
# Zero-Run Expansion Decoder

This block sits directly after a variable-length decoder. It turns that decoder's tagged 8-bit symbols into a plain stream of 7-bit samples. A symbol whose top bit is clear is a literal: its low seven bits leave the block as one sample. A symbol whose top bit is set is a run: its low seven bits give a count N, and the block emits N zero-valued samples on consecutive accepted output cycles.

Both sides use a valid/ready handshake. While a run is being expanded, the input ready stays low. This low ready is the stall that holds the upstream decoder until the block can take another symbol.

A literal and the first zero of a run are presented in the same cycle the symbol is accepted. As a result, the block sustains one output sample per clock whenever the downstream side is ready.

Top module: `zrun_expander`

## Requirements
- R1: A symbol with bit 7 equal to 0, accepted while in_valid and in_ready are both high, drives out_valid high with out_sample equal to its bits 6..0 in that same cycle.
- R2: A symbol with bit 7 equal to 1 and count N (bits 6..0) in the range 1 to 127 produces exactly N output samples of value 0. The first is presented in the acceptance cycle, the rest on the following handshaken cycles, and no other sample is placed between them.
- R3: After a run symbol with N of 2 or more is accepted, in_ready stays low until the last of its zeros has been taken by out_ready. With out_ready held high, the next symbol is accepted exactly N cycles after the run symbol.
- R4: A run symbol with count 0 (value 0x80) is accepted in one cycle, produces no output sample (out_valid low in that cycle), and leaves the block ready for the next symbol in the following cycle.
- R5: While out_valid is high and out_ready is low, the block holds out_valid high and out_sample unchanged into the next cycle, and the number of remaining zeros of a run does not change.
- R6: With out_ready held high, a sequence of literal symbols offered back to back is accepted one per clock, giving one output sample per clock.
- R7: After reset, while no run is pending, in_ready follows out_ready and out_valid is low whenever in_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Upstream symbol valid |
| in_ready | output | 1 | Block can take a symbol; low is the stall to the upstream decoder |
| in_sym | input | 8 | Tagged symbol: bit 7 selects run (1) or literal (0), bits 6..0 hold the count or the sample |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts the sample |
| out_sample | output | 7 | Decoded sample |

## Verification
A literal and the first zero of a run are due at the outputs in the same cycle the symbol is accepted, with no register in between. Each further zero of a run is due one handshaken cycle after the previous one. The bench drives every input on the falling edge, checks in_ready one nanosecond later, and lets its monitor sample the outputs two nanoseconds after the falling edge, so each output is compared in the cycle it is due. Expected samples are queued by the driver in order, so any extra, missing or reordered zero shows up as a mismatch. Separate timed checks cover the N-cycle stall of a run and the one-per-clock rate of literals.

// File: rtl/zrx_pkg.sv
package zrx_pkg;

  // Symbol class carried in the top bit of each input word.
  typedef enum logic {
    SYM_LITERAL = 1'b0,
    SYM_RUN     = 1'b1
  } sym_kind_e;

endpackage

// File: rtl/zrx_rst_sync.sv
module zrx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/zrx_sym_decode.sv
module zrx_sym_decode
  import zrx_pkg::*;
#(
  parameter int SAMPLE_W = 7,
  localparam int SYM_W   = SAMPLE_W + 1
) (
  input  logic [SYM_W-1:0]    sym,
  output sym_kind_e           kind,
  output logic [SAMPLE_W-1:0] field,
  output logic                empty_run
);

  always_comb begin
    kind      = sym[SYM_W-1] ? SYM_RUN : SYM_LITERAL;
    field     = sym[SAMPLE_W-1:0];
    empty_run = (kind == SYM_RUN) && (field == '0);
  end

endmodule

// File: rtl/zrx_run_counter.sv
module zrx_run_counter #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step_en,
  output logic [CNT_W-1:0] remain,
  output logic             busy
);

  logic [CNT_W-1:0] remain_q;
  logic [CNT_W-1:0] remain_d;
  logic             remain_en;

  // Next-state: a load and a step never coincide, because loads only
  // happen while idle and steps only while busy.
  always_comb begin
    remain_en = load_en || step_en;
    remain_d  = remain_q;
    if (load_en)      remain_d = load_val;
    else if (step_en) remain_d = remain_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         remain_q <= '0;
    else if (remain_en) remain_q <= remain_d;
  end

  assign remain = remain_q;
  assign busy   = (remain_q != '0);

  // A busy counter without a step keeps its count (R5).
  assert_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step_en && !load_en) |=> (remain == $past(remain)));

  // Each step removes exactly one pending zero (R2).
  assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step_en) |=> (remain == $past(remain) - 1'b1));

endmodule

// File: rtl/zrx_out_mux.sv
module zrx_out_mux
  import zrx_pkg::*;
#(
  parameter int SAMPLE_W = 7
) (
  input  logic                busy,
  input  logic                in_valid,
  input  sym_kind_e           kind,
  input  logic                empty_run,
  input  logic [SAMPLE_W-1:0] field,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_sample
);

  always_comb begin
    if (busy) begin
      out_valid  = 1'b1;
      out_sample = '0;
    end else begin
      out_valid  = in_valid && !empty_run;
      out_sample = (kind == SYM_LITERAL) ? field : '0;
    end
  end

endmodule

// File: rtl/zrun_expander.sv
module zrun_expander
  import zrx_pkg::*;
#(
  parameter int SAMPLE_W = 7,
  parameter int RST_STAGES = 2,
  localparam int SYM_W = SAMPLE_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SYM_W-1:0]    in_sym,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_sample
);

  logic                rst_n_sync;
  sym_kind_e           kind;
  logic [SAMPLE_W-1:0] field;
  logic                empty_run;
  logic                busy;
  logic [SAMPLE_W-1:0] remain;
  logic                accept;
  logic                load_en;
  logic [SAMPLE_W-1:0] load_val;
  logic                step_en;

  zrx_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  zrx_sym_decode #(.SAMPLE_W(SAMPLE_W)) u_dec (
    .sym       (in_sym),
    .kind      (kind),
    .field     (field),
    .empty_run (empty_run)
  );

  // A new symbol is taken only while idle and while the downstream side
  // can take the sample it may produce in the same cycle.
  always_comb begin
    in_ready = !busy && out_ready;
    accept   = in_valid && in_ready;
    load_en  = accept && (kind == SYM_RUN) && !empty_run;
    load_val = field - 1'b1;
    step_en  = busy && out_ready;
  end

  zrx_run_counter #(.CNT_W(SAMPLE_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .load_en  (load_en),
    .load_val (load_val),
    .step_en  (step_en),
    .remain   (remain),
    .busy     (busy)
  );

  zrx_out_mux #(.SAMPLE_W(SAMPLE_W)) u_mux (
    .busy       (busy),
    .in_valid   (in_valid),
    .kind       (kind),
    .empty_run  (empty_run),
    .field      (field),
    .out_valid  (out_valid),
    .out_sample (out_sample)
  );

  assert_literal_pass_R1: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (in_valid && in_ready && !in_sym[SYM_W-1]) |->
      (out_valid && out_sample == in_sym[SAMPLE_W-1:0]));

  assert_run_zero_R2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (in_valid && in_ready && in_sym[SYM_W-1] && in_sym[SAMPLE_W-1:0] != '0) |->
      (out_valid && out_sample == '0));

  assert_run_stall_R3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (in_valid && in_ready && in_sym[SYM_W-1] && in_sym[SAMPLE_W-1:0] > 1) |=>
      (!in_ready && out_valid && out_sample == '0));

  assert_empty_run_R4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (in_valid && in_ready && in_sym == {1'b1, {SAMPLE_W{1'b0}}}) |->
      !out_valid);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (busy && !out_ready) |=> (out_valid && $stable(out_sample) && !in_ready));

endmodule

// File: tb/zrun_expander_tb.sv
module zrun_expander_tb;

  localparam int SW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [SW:0]   in_sym = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [SW-1:0] out_sample;

  int checks = 0;
  int errors = 0;
  int cycle  = 0;
  bit rand_ready = 1'b0;
  bit done = 1'b0;

  logic [SW-1:0] exp_q[$];
  string         tag_q[$];

  always #4 clk = ~clk;

  zrun_expander u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_sym     (in_sym),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_sample (out_sample)
  );

  always @(posedge clk) cycle <= cycle + 1;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, expv, cycle);
    end
  endtask

  // Downstream ready pattern, changed on the falling edge.
  always @(negedge clk) begin
    if (rand_ready) out_ready <= ($urandom_range(0, 3) != 0);
  end

  // Monitor: compares each handshaken sample with the queue, and checks hold.
  bit            prev_stall = 1'b0;
  logic [SW-1:0] prev_sample = '0;
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (prev_stall) begin
        check(out_valid && out_sample == prev_sample, "R5", int'(out_sample), int'(prev_sample));
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", int'(out_sample), -1);
        end else begin
          logic [SW-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_sample == e, t, int'(out_sample), int'(e));
        end
      end
      prev_stall  = out_valid && !out_ready;
      prev_sample = out_sample;
    end
  end

  // Driver: queues expected samples and holds the symbol until accepted.
  task automatic send(input logic [SW:0] sym);
    if (sym[SW] == 1'b0) begin
      exp_q.push_back(sym[SW-1:0]);
      tag_q.push_back("R1");
    end else begin
      for (int k = 0; k < int'(sym[SW-1:0]); k++) begin
        exp_q.push_back('0);
        tag_q.push_back("R2");
      end
    end
    @(negedge clk);
    in_valid = 1'b1;
    in_sym   = sym;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    if (sym == 8'h80) check(!out_valid, "R4", int'(out_valid), 0);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Back-to-back send without a bubble, used for rate checks.
  task automatic send_burst_literals(input int n, input logic [SW-1:0] base);
    int start;
    @(negedge clk);
    start = cycle;
    for (int k = 0; k < n; k++) begin
      logic [SW-1:0] v;
      v = base + SW'(k);
      exp_q.push_back(v);
      tag_q.push_back("R1");
      in_valid = 1'b1;
      in_sym   = {1'b0, v};
      #1;
      check(in_ready, "R6", int'(in_ready), 1);
      @(negedge clk);
    end
    in_valid = 1'b0;
    check(cycle - start == n, "R6", cycle - start, n);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int t0;
    #13 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R7: idle after reset
    check(in_ready == 1'b1, "R7", int'(in_ready), 1);
    check(out_valid == 1'b0, "R7", int'(out_valid), 0);
    out_ready = 1'b0;
    #1;
    check(in_ready == 1'b0, "R7", int'(in_ready), 0);
    @(negedge clk);
    out_ready = 1'b1;

    // R1 literals
    send(8'h00);
    send(8'h7F);
    send(8'h2A);
    // R2 runs of 1 and 3
    send(8'h81);
    send(8'h83);
    // R4 empty run, then a literal must follow immediately
    send(8'h80);
    send(8'h11);

    // R3: a run of 5 stalls input for exactly 5 cycles
    @(negedge clk);
    exp_q.push_back('0); tag_q.push_back("R2");
    exp_q.push_back('0); tag_q.push_back("R2");
    exp_q.push_back('0); tag_q.push_back("R2");
    exp_q.push_back('0); tag_q.push_back("R2");
    exp_q.push_back('0); tag_q.push_back("R2");
    in_valid = 1'b1;
    in_sym   = 8'h85;
    #1;
    check(in_ready, "R3", int'(in_ready), 1);
    t0 = cycle;
    @(negedge clk);
    exp_q.push_back(7'h55); tag_q.push_back("R1");
    in_sym = 8'h55;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    check(cycle - t0 == 5, "R3", cycle - t0, 5);
    @(negedge clk);
    in_valid = 1'b0;

    // R6: literals at one per clock
    send_burst_literals(10, 7'h30);

    // R5: random downstream stalls over mixed symbols
    rand_ready = 1'b1;
    for (int i = 0; i < 200; i++) begin
      logic [SW:0] s;
      s = 8'($urandom);
      if (s[SW]) s[SW-1:0] = s[SW-1:0] & 7'h0F;
      send(s);
    end
    send(8'hFF);
    send(8'h80);
    rand_ready = 1'b0;
    @(negedge clk);
    out_ready = 1'b1;
    repeat (300) @(negedge clk);
    check(exp_q.size() == 0, "R2", exp_q.size(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule